// File: doc/BRIEF.md
# Flash Programming Access Security Gate

This block decides whether an external programmer may read or rewrite the on-chip flash. It sits between the programmer's command stream and the flash controller. A command is passed on only while access is granted. Any other command is dropped, and the block raises a one-cycle reject strobe for it.

Protection depends on the programming mode.
- **Parallel mode:** the gate reads one protect byte from user flash and decodes a lock field and a release field from it.
- **Serial and CAN modes:** the gate reads seven stored identification bytes from fixed, non-contiguous flash addresses. It compares them, in order, with the ID bytes the programmer sends. A device whose stored ID bytes all read FFh is treated as blank, and the gate grants access without any comparison.

Stored bytes are fetched through a simple read port. A read request is answered by a valid pulse after any latency. Every mode change clears the grant and restarts the fetch.

Top module: `flash_sec_gate`

## Requirements
- R1: After reset, `access_granted`, `cmd_reject`, `fwd_valid` and `rd_req` are all low.
- R2: `mode` selects the programming mode: 00 is parallel, 01 is serial, 10 is CAN and 11 is off. In parallel mode the protect byte is read from address `PROT_ADDR`. Bits [1:0] of that byte form the lock field and bits [5:4] form the release field. The part is locked when the lock field is not 11 and the release field is not 00. While locked, every read and every write is rejected.
- R3: In parallel mode, a release field of 00 or a lock field of 11 grants access. Each accepted command appears on the `fwd_*` outputs one cycle later with its fields unchanged.
- R4: In parallel mode, a forwarded write to `PROT_ADDR` becomes the gate's protect byte from the next cycle on. While the part is locked, a write to `PROT_ADDR` is rejected and the lock stays in force.
- R5: On entry to serial or CAN mode, the gate reads byte addresses FFFDF, FFFE3, FFFEB, FFFEF, FFFF3, FFFF7 and FFFFB (hex), one at a time and in that order. On entry to parallel mode, it reads only `PROT_ADDR`.
- R6: In serial or CAN mode, if all seven stored ID bytes read FFh, access is granted without any ID byte being received.
- R7: The received ID bytes are compared in arrival order with the stored bytes. Access is granted in the cycle after the seventh byte, and only if no byte differed. It is not granted before that.
- R8: A single differing ID byte blocks the grant until the next mode change. ID bytes received after the seventh are ignored.
- R9: Each command received while access is not granted gives exactly one cycle of `cmd_reject`, one cycle after the command, and is not forwarded. `cmd_reject` and `fwd_valid` are never high together.
- R10: A change on `mode` drops `access_granted` in the same cycle and restarts the check for the new mode. Mode 11 never grants access.
- R11: In serial and CAN modes the protect byte has no effect. Once access is granted, a write to `PROT_ADDR` is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Programming mode: 00 parallel, 01 serial, 10 CAN, 11 off |
| rd_req | output | 1 | Flash read request, one cycle per read |
| rd_addr | output | 20 | Flash byte address of the read |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | 8 | Read data |
| id_valid | input | 1 | Programmer ID byte valid |
| id_byte | input | 8 | Programmer ID byte |
| cmd_valid | input | 1 | Programmer command valid |
| cmd_write | input | 1 | Command is a write (1) or a read (0) |
| cmd_addr | input | 20 | Command flash address |
| cmd_wdata | input | 8 | Command write data |
| access_granted | output | 1 | Programmer access is currently allowed |
| cmd_reject | output | 1 | One-cycle strobe for a refused command |
| fwd_valid | output | 1 | Forwarded command valid |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | 20 | Forwarded address |
| fwd_wdata | output | 8 | Forwarded write data |

## Verification
The bench builds the gate with its default `PROT_ADDR` of FFFFF. That address lies apart from the seven ID slots, so a write to the protect byte can be told apart from the ID fetch in both mode families. The flash model answers each read after a random delay of one to three cycles. This exercises the wait-for-valid path on every one of the seven fetches. With the seven-byte ID length, a mismatch can be placed at every position, including the first and the last, within a few hundred cycles.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int ID_LEN = 7;
    localparam int IDX_W  = $clog2(ID_LEN);
    localparam int CNT_W  = $clog2(ID_LEN + 1);
    localparam int FA_W   = 20;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        GM_PARALLEL = 2'b00,
        GM_SERIAL   = 2'b01,
        GM_CAN      = 2'b10,
        GM_OFF      = 2'b11
    } gate_mode_e;

    typedef struct packed {
        logic              write;
        logic [FA_W-1:0]   addr;
        logic [BYTE_W-1:0] wdata;
    } flash_cmd_t;

    // Stored ID byte slot k -> flash byte address
    function automatic logic [FA_W-1:0] id_slot_addr(input logic [IDX_W-1:0] k);
        case (k)
            3'd0:    return 20'hFFFDF;
            3'd1:    return 20'hFFFE3;
            3'd2:    return 20'hFFFEB;
            3'd3:    return 20'hFFFEF;
            3'd4:    return 20'hFFFF3;
            3'd5:    return 20'hFFFF7;
            default: return 20'hFFFFB;
        endcase
    endfunction

    function automatic logic is_id_slot(input logic [FA_W-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < ID_LEN; k++) begin
            if (a == id_slot_addr(IDX_W'(k))) hit = 1'b1;
        end
        return hit;
    endfunction

    // Lock field in [1:0], release field in [5:4]
    function automatic logic prot_locked(input logic [BYTE_W-1:0] b);
        return (b[1:0] != 2'b11) && (b[5:4] != 2'b00);
    endfunction

    function automatic logic is_serial_type(input gate_mode_e m);
        return (m == GM_SERIAL) || (m == GM_CAN);
    endfunction

endpackage

// File: rtl/fsg_fetch.sv
module fsg_fetch
    import fsg_pkg::*;
#(
    parameter logic [FA_W-1:0] PROT_ADDR = 20'hFFFFF
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic                            serial_run,
    output logic                            rd_req,
    output logic [FA_W-1:0]                 rd_addr,
    input  logic                            rd_valid,
    input  logic [BYTE_W-1:0]               rd_data,
    output logic [ID_LEN-1:0][BYTE_W-1:0]   bytes_out,
    output logic                            done
);

    localparam logic [IDX_W-1:0] LAST_SER = IDX_W'(ID_LEN - 1);

    logic                          busy_q;
    logic                          wait_q;
    logic                          done_q;
    logic                          ser_q;
    logic [IDX_W-1:0]              idx_q;
    logic [ID_LEN-1:0][BYTE_W-1:0] buf_q;
    logic [IDX_W-1:0]              last_idx;

    assign last_idx  = ser_q ? LAST_SER : '0;
    assign rd_req    = busy_q && !wait_q;
    assign rd_addr   = ser_q ? id_slot_addr(idx_q) : PROT_ADDR;
    assign bytes_out = buf_q;
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            wait_q <= 1'b0;
            done_q <= 1'b0;
            ser_q  <= 1'b0;
            idx_q  <= '0;
            buf_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            wait_q <= 1'b0;
            done_q <= 1'b0;
            ser_q  <= serial_run;
            idx_q  <= '0;
        end else if (rd_req) begin
            wait_q <= 1'b1;
        end else if (busy_q && wait_q && rd_valid) begin
            buf_q[idx_q] <= rd_data;
            wait_q       <= 1'b0;
            if (idx_q == last_idx) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fsg_id_cmp.sv
module fsg_id_cmp
    import fsg_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clear,
    input  logic                            armed,
    input  logic [ID_LEN-1:0][BYTE_W-1:0]   stored,
    input  logic                            id_valid,
    input  logic [BYTE_W-1:0]               id_byte,
    output logic                            grant,
    output logic                            mism
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ID_LEN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ID_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mism_q;
    logic             grant_q;
    logic             blank;
    logic             diff;
    logic             mism_n;

    assign blank  = &stored;
    assign diff   = id_byte != stored[cnt_q[IDX_W-1:0]];
    assign mism_n = mism_q || diff;
    assign grant  = grant_q;
    assign mism   = mism_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q   <= '0;
            mism_q  <= 1'b0;
            grant_q <= 1'b0;
        end else if (armed) begin
            if (blank) begin
                grant_q <= 1'b1;
            end else if (id_valid && (cnt_q < FULL_CNT)) begin
                cnt_q  <= cnt_q + 1'b1;
                mism_q <= mism_n;
                if ((cnt_q == LAST_CNT) && !mism_n) grant_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fsg_cmd_gate.sv
module fsg_cmd_gate
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       allow,
    input  logic       in_valid,
    input  flash_cmd_t in_cmd,
    output logic       out_valid,
    output flash_cmd_t out_cmd,
    output logic       reject
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            reject    <= 1'b0;
            out_cmd   <= '0;
        end else begin
            out_valid <= in_valid && allow;
            reject    <= in_valid && !allow;
            if (in_valid && allow) out_cmd <= in_cmd;
        end
    end

endmodule

// File: rtl/flash_sec_gate.sv
module flash_sec_gate
    import fsg_pkg::*;
#(
    parameter logic [FA_W-1:0] PROT_ADDR = 20'hFFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    output logic              rd_req,
    output logic [FA_W-1:0]   rd_addr,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              id_valid,
    input  logic [BYTE_W-1:0] id_byte,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [FA_W-1:0]   cmd_addr,
    input  logic [BYTE_W-1:0] cmd_wdata,
    output logic              access_granted,
    output logic              cmd_reject,
    output logic              fwd_valid,
    output logic              fwd_write,
    output logic [FA_W-1:0]   fwd_addr,
    output logic [BYTE_W-1:0] fwd_wdata
);

    gate_mode_e mode_in;
    gate_mode_e mode_q;
    logic       mode_chg;
    logic       start;
    logic       ser_q;

    logic [ID_LEN-1:0][BYTE_W-1:0] fetched;
    logic       fetch_done;
    logic       id_grant;
    logic       id_mism;

    logic              prot_vld;
    logic [BYTE_W-1:0] prot_q;
    logic              par_ok;
    logic              ser_ok;

    flash_cmd_t cmd_in;
    flash_cmd_t cmd_out;

    assign mode_in  = gate_mode_e'(mode);
    assign mode_chg = mode_in != mode_q;
    assign start    = mode_chg && (mode_in != GM_OFF);
    assign ser_q    = is_serial_type(mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= GM_OFF;
        else     mode_q <= mode_in;
    end

    fsg_fetch #(.PROT_ADDR(PROT_ADDR)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .serial_run(is_serial_type(mode_in)),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .bytes_out (fetched),
        .done      (fetch_done)
    );

    fsg_id_cmp u_idc (
        .clk     (clk),
        .rst     (rst),
        .clear   (mode_chg),
        .armed   (fetch_done && ser_q),
        .stored  (fetched),
        .id_valid(id_valid),
        .id_byte (id_byte),
        .grant   (id_grant),
        .mism    (id_mism)
    );

    // Working copy of the protect byte for parallel mode
    always_ff @(posedge clk) begin
        if (rst || mode_chg) begin
            prot_vld <= 1'b0;
            prot_q   <= '1;
        end else if (mode_q == GM_PARALLEL) begin
            if (fetch_done && !prot_vld) begin
                prot_q   <= fetched[0];
                prot_vld <= 1'b1;
            end else if (fwd_valid && cmd_out.write && (cmd_out.addr == PROT_ADDR)) begin
                prot_q <= cmd_out.wdata;
            end
        end
    end

    assign par_ok = (mode_q == GM_PARALLEL) && prot_vld && !prot_locked(prot_q);
    assign ser_ok = ser_q && id_grant;
    assign access_granted = (par_ok || ser_ok) && !mode_chg;

    assign cmd_in = '{write: cmd_write, addr: cmd_addr, wdata: cmd_wdata};

    fsg_cmd_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .allow    (access_granted),
        .in_valid (cmd_valid),
        .in_cmd   (cmd_in),
        .out_valid(fwd_valid),
        .out_cmd  (cmd_out),
        .reject   (cmd_reject)
    );

    assign fwd_write = cmd_out.write;
    assign fwd_addr  = cmd_out.addr;
    assign fwd_wdata = cmd_out.wdata;

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
    import fsg_pkg::*;
#(
    parameter logic [FA_W-1:0] PROT_ADDR = 20'hFFFFF
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      mode,
    input logic            rd_req,
    input logic [FA_W-1:0] rd_addr,
    input logic            cmd_valid,
    input logic            access_granted,
    input logic            cmd_reject,
    input logic            fwd_valid,
    input logic            id_grant,
    input logic            id_mism
);

    a_r9_reject_after_denied: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !access_granted) |=> (cmd_reject && !fwd_valid));

    a_r3_forward_after_grant: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && access_granted) |=> (fwd_valid && !cmd_reject));

    a_r9_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!cmd_reject && !fwd_valid));

    a_r10_mode_change_drops: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |-> !access_granted);

    a_r10_off_never_grants: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |-> !access_granted);

    a_r8_mismatch_blocks: assert property (@(posedge clk) disable iff (rst)
        id_mism |-> !id_grant);

    a_r5_read_address_legal: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> ((rd_addr == PROT_ADDR) || is_id_slot(rd_addr)));

    a_r5_single_cycle_request: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

endmodule

bind flash_sec_gate fsg_checker #(.PROT_ADDR(PROT_ADDR)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode          (mode),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .cmd_valid     (cmd_valid),
    .access_granted(access_granted),
    .cmd_reject    (cmd_reject),
    .fwd_valid     (fwd_valid),
    .id_grant      (id_grant),
    .id_mism       (id_mism)
);

// File: tb/sim_flash_sec_gate.sv
`timescale 1ns/1ps
module sim_flash_sec_gate;

    localparam logic [19:0] PADDR = 20'hFFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b11;
    logic        rd_req;
    logic [19:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        id_valid = 1'b0;
    logic [7:0]  id_byte = 8'h00;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [19:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        access_granted;
    logic        cmd_reject;
    logic        fwd_valid;
    logic        fwd_write;
    logic [19:0] fwd_addr;
    logic [7:0]  fwd_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_sec_gate #(.PROT_ADDR(PADDR)) u0 (
        .clk(clk), .rst(rst), .mode(mode),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .id_valid(id_valid), .id_byte(id_byte),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .access_granted(access_granted), .cmd_reject(cmd_reject),
        .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata)
    );

    // Flash model contents
    logic [7:0]  fl_id [7];
    logic [7:0]  fl_prot;
    logic [19:0] slot_tab [7] = '{20'hFFFDF, 20'hFFFE3, 20'hFFFEB, 20'hFFFEF,
                                  20'hFFFF3, 20'hFFFF7, 20'hFFFFB};
    logic [19:0] addr_log [16];
    int          log_n = 0;

    function automatic logic [7:0] flash_byte(input logic [19:0] a);
        if (a == PADDR) return fl_prot;
        for (int k = 0; k < 7; k++) if (a == slot_tab[k]) return fl_id[k];
        return 8'hFF;
    endfunction

    function automatic bit exp_locked(input logic [7:0] b);
        return (b[1:0] != 2'b11) && (b[5:4] != 2'b00);
    endfunction

    // Read responder with random latency
    logic        pend = 1'b0;
    int          lat = 0;
    logic [19:0] pend_addr = '0;
    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else if (pend) begin
            if (lat == 0) begin
                rd_valid <= 1'b1;
                rd_data  <= flash_byte(pend_addr);
                pend     <= 1'b0;
            end else begin
                lat <= lat - 1;
            end
        end else if (rd_req) begin
            pend      <= 1'b1;
            pend_addr <= rd_addr;
            lat       <= int'($urandom % 3);
            if (log_n < 16) addr_log[log_n] <= rd_addr;
            log_n     <= log_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic enter(input logic [1:0] m);
        mode = 2'b11;
        repeat (2) @(negedge clk);
        log_n = 0;
        mode = m;
        repeat (45) @(negedge clk);
    endtask

    task automatic send_cmd(input string req, input logic w, input logic [19:0] a,
                            input logic [7:0] d, input bit exp_fwd);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, {31'd0, fwd_valid}, {31'd0, exp_fwd});
        chk(req, {31'd0, cmd_reject}, {31'd0, !exp_fwd});
        if (exp_fwd) chk(req, {3'd0, fwd_write, fwd_addr, fwd_wdata}, {3'd0, w, a, d});
        @(negedge clk);
        chk(req, {30'd0, cmd_reject, fwd_valid}, 32'd0);
    endtask

    task automatic send_id(input logic [7:0] b);
        id_valid = 1'b1; id_byte = b;
        @(negedge clk);
        id_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 7; k++) fl_id[k] = 8'hFF;
        fl_prot = 8'hFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 grant", {31'd0, access_granted}, 0);
        chk("R1 strobes", {29'd0, cmd_reject, fwd_valid, rd_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 off mode", {31'd0, access_granted}, 0);
        send_cmd("R10 off rejects", 1'b0, 20'h00010, 8'h00, 1'b0);

        // R2/R3 parallel decode, directed and random
        for (int t = 0; t < 14; t++) begin
            logic [7:0] pb;
            case (t)
                0: pb = 8'hFF;
                1: pb = 8'h00;
                2: pb = 8'h13;
                3: pb = 8'h12;
                4: pb = 8'h31;
                default: pb = 8'($urandom);
            endcase
            fl_prot = pb;
            enter(2'b00);
            if (t == 0) begin
                chk("R5 parallel read count", log_n, 1);
                chk("R5 parallel read addr", {12'd0, addr_log[0]}, {12'd0, PADDR});
            end
            chk(exp_locked(pb) ? "R2 locked grant" : "R3 unlocked grant",
                {31'd0, access_granted}, {31'd0, !exp_locked(pb)});
            send_cmd(exp_locked(pb) ? "R2 read" : "R3 read", 1'b0, 20'($urandom), 8'h00, !exp_locked(pb));
            send_cmd(exp_locked(pb) ? "R2 write" : "R3 write", 1'b1, 20'($urandom), 8'($urandom), !exp_locked(pb));
        end

        // R4 protect byte rewrite in parallel mode
        fl_prot = 8'hFF;
        enter(2'b00);
        send_cmd("R4 lock write forwarded", 1'b1, PADDR, 8'h12, 1'b1);
        chk("R4 lock takes effect", {31'd0, access_granted}, 0);
        send_cmd("R4 read after lock", 1'b0, 20'h00100, 8'h00, 1'b0);
        send_cmd("R4 release write blocked", 1'b1, PADDR, 8'h03, 1'b0);
        repeat (2) @(negedge clk);
        chk("R4 still locked", {31'd0, access_granted}, 0);

        // R11 protect byte ignored in serial modes
        fl_prot = 8'h10;
        for (int k = 0; k < 7; k++) fl_id[k] = 8'h20 + 8'(k);
        enter(2'b01);
        for (int k = 0; k < 7; k++) send_id(fl_id[k]);
        chk("R11 serial grant despite lock", {31'd0, access_granted}, 1);
        send_cmd("R11 protect write forwarded", 1'b1, PADDR, 8'h33, 1'b1);

        // R6 blank bypass
        for (int k = 0; k < 7; k++) fl_id[k] = 8'hFF;
        enter(2'b10);
        chk("R6 blank grant", {31'd0, access_granted}, 1);
        send_cmd("R6 blank command", 1'b0, 20'h00004, 8'h00, 1'b1);

        // R5/R7/R8 random ID sequences
        for (int t = 0; t < 16; t++) begin
            int   bad;
            logic [1:0] m;
            m = (t % 2 == 0) ? 2'b01 : 2'b10;
            for (int k = 0; k < 7; k++) fl_id[k] = 8'($urandom);
            fl_id[0] = fl_id[0] & 8'h7F;
            bad = (t < 8) ? -1 : (t - 8) % 7;
            enter(m);
            chk("R5 serial read count", log_n, 7);
            for (int k = 0; k < 7; k++)
                chk("R5 serial read order", {12'd0, addr_log[k]}, {12'd0, slot_tab[k]});
            for (int k = 0; k < 7; k++) begin
                chk("R7 no early grant", {31'd0, access_granted}, 0);
                send_id((k == bad) ? (fl_id[k] ^ (8'($urandom) | 8'h01)) : fl_id[k]);
            end
            if (bad < 0) begin
                chk("R7 grant after seventh", {31'd0, access_granted}, 1);
                send_cmd("R7 command accepted", 1'b1, 20'($urandom), 8'($urandom), 1'b1);
            end else begin
                chk("R8 mismatch no grant", {31'd0, access_granted}, 0);
                for (int k = 0; k < 7; k++) send_id(fl_id[k]);
                chk("R8 extra bytes ignored", {31'd0, access_granted}, 0);
                send_cmd("R8 command rejected", 1'b0, 20'($urandom), 8'h00, 1'b0);
            end
        end

        // R10 mode change drops grant at once and restarts
        for (int k = 0; k < 7; k++) fl_id[k] = 8'h40 + 8'(k);
        enter(2'b01);
        for (int k = 0; k < 7; k++) send_id(fl_id[k]);
        chk("R10 granted before switch", {31'd0, access_granted}, 1);
        mode = 2'b10;
        #1;
        chk("R10 drop same cycle", {31'd0, access_granted}, 0);
        repeat (45) @(negedge clk);
        chk("R10 new mode needs ID", {31'd0, access_granted}, 0);
        for (int k = 0; k < 7; k++) send_id(fl_id[k]);
        chk("R10 regrant in new mode", {31'd0, access_granted}, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule